// File: doc/BRIEF.md
# Interrupt Flag Register with Deferred Request Stage

This block holds the interrupt-request flags of a small processor subsystem. Five peripheral sources raise single-cycle request pulses. A pulse does not set its flag at once. It is first captured in a hidden deferred stage. On the next processor step the deferred bits are folded into the visible flag register. A software read sees the stored flags merged with any bits still deferred, and the unused upper bits of the read always return ones.

The processor side gets a pending vector and a wake signal. The pending vector is the enable mask ANDed with the flags. While the processor runs, it also includes the deferred bits. While the processor is halted, the deferred bits are left out, so a halted core only wakes on a request one step later than a running core would notice it. Writing the flag register discards every deferred bit and loads the written value. A request arriving in the same cycle as a write is still kept: it lands in the deferred stage behind the write. Vector dispatch and master-enable handling belong to the processor and are not part of this block.

Top module: `irq_flag_unit`

## Requirements
- R1: After a synchronous active-low reset, both the flags and the deferred stage are zero: the read value is 0xE0, the pending vector is 0 and wake is low.
- R2: The read value is 0xE0 ORed with the stored flags and ORed with the deferred bits in bits 4:0. Bits 7:5 always read as one.
- R3: A request pulse on source bit k appears in bit k of the deferred stage after the next clock edge. The source bits are: 0 vertical blank, 1 display status, 2 timer, 3 serial, and 4 keypad.
- R4: On a cycle with a step and no write, the deferred bits are ORed into the flags and the deferred stage is cleared. Requests arriving in that same cycle become the new deferred contents.
- R5: A write clears the deferred stage and loads the flags from write data bits 4:0. Write data bits 7:5 have no effect.
- R6: When a write and a request arrive in the same cycle, the flags take the written value and the request bit is held in the deferred stage.
- R7: While halted, the pending vector equals enable AND flags, and deferred bits are excluded.
- R8: While not halted, the pending vector equals enable AND (flags OR deferred bits).
- R9: Wake is high exactly when the pending vector is nonzero.
- R10: Without a write, no bit of the read value's bits 4:0 ever goes from one to zero, whether or not a step occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_i | input | 5 | Single-cycle request pulses, one per source |
| ie_i | input | 5 | Interrupt enable mask |
| wr_en_i | input | 1 | Write strobe for the flag register |
| wr_data_i | input | 8 | Write data for the flag register |
| step_i | input | 1 | Processor step strobe; promotes deferred bits to flags |
| halted_i | input | 1 | The processor is in the halt state |
| rd_data_o | output | 8 | Formatted flag read value |
| pending_o | output | 5 | Enabled pending requests presented to the processor |
| wake_o | output | 1 | Ends the halt state when high |

## Verification
A fault in the deferred stage shows up one cycle after a request pulse. It appears as a mismatch between the read value and the halted pending vector, because only the halted vector separates flags from deferred bits. A fault in the promotion logic shows up on the first step after a request: a halted core either sees its flag while the flag should still be hidden, or never sees it at all. Write-versus-request collisions and a write's clearing of deferred bits show up in the read value on the very next cycle. For that reason the bench compares every output on every cycle against an independent model, in both the halted and the running state.

// File: rtl/irqf_pkg.sv
// Package: shared constants for the interrupt flag unit.
// Assumes five request sources and an eight-bit register data path.
package irqf_pkg;
    localparam int IRQ_SRC_N  = 5;
    localparam int IRQ_DATA_W = 8;

    // Bit position of each request source in every vector of the block
    typedef enum int {
        SRC_VBLANK = 0,
        SRC_STATUS = 1,
        SRC_TIMER  = 2,
        SRC_SERIAL = 3,
        SRC_KEYPAD = 4
    } irq_src_e;
endpackage

// File: rtl/irqf_defer_stage.sv
// Module: deferred request stage.
// Captures request pulses for one step before they become visible flags.
// A write or a step empties the stage; requests of that cycle refill it.
// Assumes requests are single-cycle pulses; a held request re-sets its bit.
module irqf_defer_stage #(
    parameter int N = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] req_i,
    input  logic         wr_en_i,
    input  logic         step_i,
    output logic [N-1:0] defer_o
);
    logic [N-1:0] defer_q;
    logic [N-1:0] defer_d;
    logic         flush;

    // Stage is emptied by a write (clear) or a step (promotion)
    always_comb begin
        flush   = wr_en_i | step_i;
        defer_d = flush ? req_i : (defer_q | req_i);
    end

    // Deferred bit storage
    always_ff @(posedge clk) begin
        if (!rst_n) defer_q <= '0;
        else        defer_q <= defer_d;
    end

    assign defer_o = defer_q;

    // R3
    req_land_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i != '0) |=> ((defer_o & $past(req_i)) == $past(req_i)));
endmodule

// File: rtl/irqf_flag_store.sv
// Module: visible interrupt flag register.
// Loads the written value on a write; otherwise ORs in deferred bits on a step.
// Assumes the caller passes only the low N bits of write data.
module irqf_flag_store #(
    parameter int N = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en_i,
    input  logic [N-1:0] wr_bits_i,
    input  logic         step_i,
    input  logic [N-1:0] defer_i,
    output logic [N-1:0] flag_o
);
    logic [N-1:0] flag_q;
    logic [N-1:0] flag_d;

    // Next flag value: a write wins, then a step promotes deferred bits
    always_comb begin
        if (wr_en_i)     flag_d = wr_bits_i;
        else if (step_i) flag_d = flag_q | defer_i;
        else             flag_d = flag_q;
    end

    // Flag storage
    always_ff @(posedge clk) begin
        if (!rst_n) flag_q <= '0;
        else        flag_q <= flag_d;
    end

    assign flag_o = flag_q;

    // R4
    merge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && !wr_en_i) |=> (flag_o == ($past(flag_o) | $past(defer_i))));
endmodule

// File: rtl/irqf_pending.sv
// Module: pending vector and wake generation.
// Deferred bits count only while the processor is not halted.
// Purely combinational; assumes all inputs are stable within a cycle.
module irqf_pending #(
    parameter int N = 5
) (
    input  logic [N-1:0] ie_i,
    input  logic [N-1:0] flag_i,
    input  logic [N-1:0] defer_i,
    input  logic         halted_i,
    output logic [N-1:0] pending_o,
    output logic         wake_o
);
    // Per-source pending bit with the halt visibility rule
    for (genvar k = 0; k < N; k++) begin : g_src
        logic seen;
        always_comb seen = flag_i[k] | (defer_i[k] & ~halted_i);
        assign pending_o[k] = ie_i[k] & seen;
    end

    // Any pending source ends the halt state
    always_comb wake_o = |pending_o;
endmodule

// File: rtl/irq_flag_unit.sv
// Module: interrupt flag unit, top level.
// Combines the deferred stage, the flag register and the pending logic, and
// formats the read value with ones above the source bits.
// Assumes DW > N and synchronous active-low reset.
module irq_flag_unit #(
    parameter int N  = irqf_pkg::IRQ_SRC_N,
    parameter int DW = irqf_pkg::IRQ_DATA_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  req_i,
    input  logic [N-1:0]  ie_i,
    input  logic          wr_en_i,
    input  logic [DW-1:0] wr_data_i,
    input  logic          step_i,
    input  logic          halted_i,
    output logic [DW-1:0] rd_data_o,
    output logic [N-1:0]  pending_o,
    output logic          wake_o
);
    localparam int FILL_W = DW - N;

    logic [N-1:0] defer_w;
    logic [N-1:0] flag_w;
    logic         unused_wr_hi;

    // Upper write bits carry no state
    assign unused_wr_hi = ^wr_data_i[DW-1:N];

    irqf_defer_stage #(.N(N)) defer_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .req_i   (req_i),
        .wr_en_i (wr_en_i),
        .step_i  (step_i),
        .defer_o (defer_w)
    );

    irqf_flag_store #(.N(N)) store_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (wr_en_i),
        .wr_bits_i (wr_data_i[N-1:0]),
        .step_i    (step_i),
        .defer_i   (defer_w),
        .flag_o    (flag_w)
    );

    irqf_pending #(.N(N)) pend_i (
        .ie_i      (ie_i),
        .flag_i    (flag_w),
        .defer_i   (defer_w),
        .halted_i  (halted_i),
        .pending_o (pending_o),
        .wake_o    (wake_o)
    );

    // Read formatting: constant ones above, merged flags and deferred bits below
    always_comb rd_data_o = {{FILL_W{1'b1}}, (flag_w | defer_w)};

    // R5
    wr_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_i |=> (rd_data_o[N-1:0] == ($past(wr_data_i[N-1:0]) | $past(req_i))));

    // R7
    halt_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        halted_i |-> ((pending_o & ~(ie_i & flag_w)) == '0));

    // R10
    no_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en_i |=> ((rd_data_o[N-1:0] & $past(rd_data_o[N-1:0])) == $past(rd_data_o[N-1:0])));
endmodule

// File: tb/irq_flag_unit_tb_top.sv
// Scoreboard bench: the driver task computes expected outputs from its own
// model and queues them; the monitor pops and compares one item per cycle.
module irq_flag_unit_tb_top;
    import irqf_pkg::*;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [4:0] req = '0;
    logic [4:0] ie = '0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic       step = 1'b0;
    logic       halted = 1'b0;
    logic [7:0] rd_data;
    logic [4:0] pending;
    logic       wake;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    logic [7:0] q_rd[$];
    logic [4:0] q_pend[$];
    logic       q_wake[$];
    string      q_tag[$];

    logic [4:0] m_flag = '0;
    logic [4:0] m_def  = '0;

    always #2.5 clk = ~clk;

    irq_flag_unit dut_i (
        .clk(clk), .rst_n(rst_n), .req_i(req), .ie_i(ie),
        .wr_en_i(wr_en), .wr_data_i(wr_data), .step_i(step),
        .halted_i(halted), .rd_data_o(rd_data), .pending_o(pending), .wake_o(wake)
    );

    // Driver: apply inputs, queue expected outputs, advance the model at the edge
    task automatic cyc(input logic r, input logic [4:0] rq, input logic w,
                       input logic [7:0] wd, input logic st, input logic [4:0] en,
                       input logic hl, input string tag);
        logic [4:0] ep;
        @(negedge clk);
        rst_n = r; req = rq; wr_en = w; wr_data = wd; step = st; ie = en; halted = hl;
        ep = (en & m_flag) | (hl ? 5'd0 : (en & m_def));
        q_rd.push_back({3'b111, m_flag | m_def});
        q_pend.push_back(ep);
        q_wake.push_back(ep != 0);
        q_tag.push_back(tag);
        @(posedge clk);
        if (!r)      begin m_flag = '0; m_def = '0; end
        else if (w)  begin m_flag = wd[4:0]; m_def = rq; end
        else if (st) begin m_flag = m_flag | m_def; m_def = rq; end
        else         m_def = m_def | rq;
    endtask

    // Monitor: compare outputs shortly after each negative edge
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (q_rd.size() > 0) begin
                logic [7:0] er; logic [4:0] ep; logic ew; string t;
                er = q_rd.pop_front(); ep = q_pend.pop_front();
                ew = q_wake.pop_front(); t = q_tag.pop_front();
                checks++;
                if (rd_data !== er || pending !== ep || wake !== ew) begin
                    fails++;
                    $display("FAIL %s: rd=%h pend=%b wake=%b expected rd=%h pend=%b wake=%b",
                             t, rd_data, pending, wake, er, ep, ew);
                end
            end
        end
    end

    // Watchdog
    initial begin
        #200000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog: run did not end, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    localparam logic [4:0] VB = 5'(1 << SRC_VBLANK);
    localparam logic [4:0] ST = 5'(1 << SRC_STATUS);
    localparam logic [4:0] TM = 5'(1 << SRC_TIMER);
    localparam logic [4:0] SE = 5'(1 << SRC_SERIAL);
    localparam logic [4:0] KP = 5'(1 << SRC_KEYPAD);

    initial begin
        logic [15:0] lfsr;
        lfsr = 16'hACE1;
        // R1: reset state
        cyc(0, 0, 0, 0, 0, 5'h1F, 0, "R1");
        cyc(0, 0, 0, 0, 0, 5'h1F, 0, "R1");
        cyc(1, 0, 0, 0, 0, 5'h1F, 0, "R1");
        cyc(1, 0, 0, 0, 0, 5'h1F, 1, "R1");
        // R3: vertical blank pulse lands deferred; halted pending stays 0
        cyc(1, VB, 0, 0, 0, 5'h1F, 1, "R3");
        cyc(1, 0, 0, 0, 0, 5'h1F, 1, "R3_R7");
        // R8: running core sees deferred bit
        cyc(1, 0, 0, 0, 0, 5'h1F, 0, "R8");
        // R4: step promotes; halted core then sees flag
        cyc(1, TM, 0, 0, 1, 5'h1F, 1, "R4");
        cyc(1, 0, 0, 0, 0, 5'h1F, 1, "R4_R7");
        cyc(1, 0, 0, 0, 0, 5'h1F, 0, "R8_R9");
        // R10: further steps keep bits
        cyc(1, 0, 0, 0, 1, 5'h1F, 1, "R10");
        cyc(1, 0, 0, 0, 1, 5'h1F, 1, "R10");
        // R5: write clears deferred stage and ignores upper bits
        cyc(1, SE, 0, 0, 0, 5'h1F, 1, "R5");
        cyc(1, 0, 1, 8'hE2, 0, 5'h1F, 1, "R5");
        cyc(1, 0, 0, 0, 0, 5'h1F, 0, "R5_R2");
        cyc(1, 0, 1, 8'h00, 1, 5'h1F, 0, "R5");
        cyc(1, 0, 0, 0, 0, 5'h1F, 0, "R5_R9");
        // R6: write and request in same cycle
        cyc(1, SE, 1, 8'h01, 0, 5'h1F, 1, "R6");
        cyc(1, 0, 0, 0, 0, 5'h1F, 1, "R6_R7");
        cyc(1, 0, 0, 0, 0, 5'h1F, 0, "R6_R8");
        // R7: partial enable mask, keypad and status
        cyc(1, KP | ST, 0, 0, 1, ST, 1, "R7");
        cyc(1, 0, 0, 0, 1, ST, 1, "R7");
        cyc(1, 0, 0, 0, 0, KP, 1, "R7_R9");
        cyc(1, 0, 0, 0, 0, 5'h02, 0, "R8");
        // R2: pseudo-random traffic
        for (int i = 0; i < 300; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            cyc(1, lfsr[4:0] & {5{lfsr[5]}}, (lfsr[9:6] == 4'd0), lfsr[15:8],
                lfsr[10], lfsr[15:11], lfsr[7], "R2");
        end
        cyc(1, 0, 0, 0, 0, 5'h1F, 0, "R2");
        @(negedge clk); #2;
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule